// File: doc/BRIEF.md
# PWM Output-Enable Update Controller

This block owns the pin-enable bits of eight PWM outputs and decides the clock edge on which a newly written enable value reaches the pins. Outputs are paired on four generators. Outputs 2k and 2k+1 follow generator k's counter-zero pulse and its global update request. Each output has a 2-bit timing mode. A written bit can take effect on the next clock. It can instead wait for the owning counter's next zero. Or it can wait for a counter zero that follows a global synchronous request made for that generator.

Software reaches the block through a small register port with a one-bit address. Address 0 selects the timing-mode register and address 1 selects the enable register. Reads are combinational. Waveform generation, the counters and the master control that raises global requests all live outside this block. It sees only their zero pulses and request strobes.

Top module: `pwm_oe_update_ctrl`

## Requirements
- R1: After reset every output enable is 0, and both the mode register and the enable register read back as 0.
- R2: The mode register (address 0) stores bits 15:0 on a write, and output n takes its mode from bits [2n+1:2n]. Bits 31:16 always read as 0.
- R3: In mode 0, a bit written to the enable register (address 1, bit n for output n) appears on out_en[n] in the cycle after the write edge.
- R4: Mode 1 behaves exactly like mode 0.
- R5: In mode 2, a written bit is held pending. It is applied at the first rising edge after the write edge on which cnt_zero of the owning generator (n/2) is high. A zero pulse sampled on the write edge itself does not apply it.
- R6: In mode 3, a pending bit is applied only on a counter-zero edge of generator n/2 when a global request for that generator was sampled on an earlier edge. A zero without such a request leaves the output and the pending bit unchanged, and so does a zero on the same edge as the request.
- R7: A latched global request is consumed by the next counter zero of its generator. Several requests before that zero count as one. A later zero with no new request does not apply a pending mode-3 bit.
- R8: Reading the enable register returns the active enables, never values that are still pending.
- R9: A write to the enable register while an update is pending replaces the pending value, and only the newest value is applied.
- R10: A counter-zero pulse of generator k changes only outputs 2k and 2k+1.
- R11: A write made while an output is in mode 0 or 1 discards any pending update for that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mode register, 1 selects the enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational readback of the addressed register |
| cnt_zero | input | 4 | Per-generator counter-zero pulse |
| gsync_req | input | 4 | Per-generator global synchronous update request |
| out_en | output | 8 | Active pin enables, one per PWM output |

## Verification
Every change of out_en is due exactly one rising edge after its cause: the enable write in modes 0 and 1, or the qualifying counter-zero pulse in modes 2 and 3. Register readback is due in the same cycle that the address is presented. The driver changes inputs just after each rising edge and queues each expected value tagged with the cycle in which it is due. The monitor compares on falling edges, so every sample falls half a period after the edge that should have produced it. Cases that must not apply are checked at exactly that edge. These include a zero on the write edge, a zero on the request edge, a zero of the wrong generator and a zero after a request has already been consumed.

// File: rtl/pwm_oe_pkg.sv
package pwm_oe_pkg;

    localparam int UPD_W = 2;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_EN   = 1'b1;

    typedef enum logic [UPD_W-1:0] {
        UPD_NOW    = 2'd0,
        UPD_ALIAS  = 2'd1,
        UPD_LOCAL  = 2'd2,
        UPD_GLOBAL = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic busy;
        logic val;
    } pend_t;

    function automatic logic is_deferred(input upd_mode_e m);
        return (m == UPD_LOCAL) || (m == UPD_GLOBAL);
    endfunction

    function automatic logic may_apply(input upd_mode_e m, input logic zero,
                                       input logic gsync_ok);
        return zero && ((m == UPD_LOCAL) || ((m == UPD_GLOBAL) && gsync_ok));
    endfunction

endpackage

// File: rtl/pwm_oe_mode_reg.sv
module pwm_oe_mode_reg #(
    parameter int MODE_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [MODE_BITS-1:0] wdata,
    output logic [MODE_BITS-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= wdata;
        end
    end
endmodule

// File: rtl/pwm_oe_gen_sync.sv
module pwm_oe_gen_sync (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic zero,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= req | (armed & ~zero);
        end
    end
endmodule

// File: rtl/pwm_oe_bit_cell.sv
module pwm_oe_bit_cell
    import pwm_oe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  upd_mode_e mode,
    input  logic      wr,
    input  logic      wbit,
    input  logic      zero,
    input  logic      gsync_ok,
    output logic      active
);
    pend_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            active <= 1'b0;
        end else if (wr) begin
            if (is_deferred(mode)) begin
                pend_q <= '{busy: 1'b1, val: wbit};
            end else begin
                pend_q <= '0;
                active <= wbit;
            end
        end else if (pend_q.busy && may_apply(mode, zero, gsync_ok)) begin
            active <= pend_q.val;
            pend_q <= '0;
        end
    end
endmodule

// File: rtl/pwm_oe_update_ctrl.sv
module pwm_oe_update_ctrl
    import pwm_oe_pkg::*;
#(
    parameter int NUM_GEN      = 4,
    parameter int OUTS_PER_GEN = 2,
    parameter int DATA_W       = 32,
    localparam int NUM_OUT     = NUM_GEN * OUTS_PER_GEN,
    localparam int MODE_BITS   = NUM_OUT * UPD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_GEN-1:0] cnt_zero,
    input  logic [NUM_GEN-1:0] gsync_req,
    output logic [NUM_OUT-1:0] out_en
);
    logic [MODE_BITS-1:0] mode_q;
    logic [NUM_GEN-1:0]   gsync_armed;
    logic                 mode_we;
    logic                 en_we;

    assign mode_we = reg_we && (reg_addr == ADDR_MODE);
    assign en_we   = reg_we && (reg_addr == ADDR_EN);

    pwm_oe_mode_reg #(.MODE_BITS(MODE_BITS)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .we     (mode_we),
        .wdata  (reg_wdata[MODE_BITS-1:0]),
        .mode_q (mode_q)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pwm_oe_gen_sync u_sync (
            .clk   (clk),
            .rst   (rst),
            .req   (gsync_req[g]),
            .zero  (cnt_zero[g]),
            .armed (gsync_armed[g])
        );
    end

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
        localparam int GEN = n / OUTS_PER_GEN;
        upd_mode_e field;
        assign field = upd_mode_e'(mode_q[n*UPD_W +: UPD_W]);

        pwm_oe_bit_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .mode     (field),
            .wr       (en_we),
            .wbit     (reg_wdata[n]),
            .zero     (cnt_zero[GEN]),
            .gsync_ok (gsync_armed[GEN]),
            .active   (out_en[n])
        );
    end

    always_comb begin
        if (reg_addr == ADDR_MODE) begin
            reg_rdata = {{(DATA_W-MODE_BITS){1'b0}}, mode_q};
        end else begin
            reg_rdata = {{(DATA_W-NUM_OUT){1'b0}}, out_en};
        end
    end
endmodule

// File: rtl/pwm_oe_update_chk.sv
module pwm_oe_update_chk
    import pwm_oe_pkg::*;
#(
    parameter int NUM_GEN   = 4,
    parameter int NUM_OUT   = 8,
    parameter int DATA_W    = 32,
    parameter int MODE_BITS = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic                 reg_addr,
    input logic [NUM_OUT-1:0]   wr_bits,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [NUM_GEN-1:0]   cnt_zero,
    input logic [NUM_GEN-1:0]   gsync_req,
    input logic [NUM_OUT-1:0]   out_en,
    input logic [MODE_BITS-1:0] mode_q,
    input logic [NUM_GEN-1:0]   gsync_armed
);
    logic [NUM_OUT-1:0] imm_mask;
    logic               en_wr;

    always_comb begin
        for (int n = 0; n < NUM_OUT; n++) begin
            imm_mask[n] = !mode_q[n*UPD_W + 1];
        end
    end

    assign en_wr = reg_we && (reg_addr == ADDR_EN);

    // R5: outputs only move after an enable write or a counter zero
    assert_chg_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_en) |-> ($past(en_wr) || $past(|cnt_zero)));

    // R3 and R4: immediate-mode bits follow the written data one edge later
    assert_imm_R3: assert property (@(posedge clk) disable iff (rst)
        $past(en_wr) |-> (((out_en ^ $past(wr_bits)) & $past(imm_mask)) == '0));

    assert_gset_R6: assert property (@(posedge clk) disable iff (rst)
        (|gsync_req) |=> ((~gsync_armed & $past(gsync_req)) == '0));

    assert_gclr_R7: assert property (@(posedge clk) disable iff (rst)
        (|(cnt_zero & ~gsync_req)) |=> ((gsync_armed & $past(cnt_zero & ~gsync_req)) == '0));

    assert_rd_active_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_EN) |-> (reg_rdata[NUM_OUT-1:0] == out_en));

    assert_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_MODE) |-> (reg_rdata[DATA_W-1:MODE_BITS] == '0));
endmodule

bind pwm_oe_update_ctrl pwm_oe_update_chk #(
    .NUM_GEN   (NUM_GEN),
    .NUM_OUT   (NUM_OUT),
    .DATA_W    (DATA_W),
    .MODE_BITS (MODE_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .wr_bits     (reg_wdata[NUM_OUT-1:0]),
    .reg_rdata   (reg_rdata),
    .cnt_zero    (cnt_zero),
    .gsync_req   (gsync_req),
    .out_en      (out_en),
    .mode_q      (mode_q),
    .gsync_armed (gsync_armed)
);

// File: tb/tb_pwm_oe_update_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_oe_update_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  cnt_zero = '0;
    logic [3:0]  gsync_req = '0;
    logic [7:0]  out_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    pwm_oe_update_ctrl dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_zero(cnt_zero),
        .gsync_req(gsync_req), .out_en(out_en)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic drive(input logic we, input logic addr, input logic [31:0] d,
                         input logic [3:0] z, input logic [3:0] g);
        @(posedge clk);
        #1;
        reg_we = we; reg_addr = addr; reg_wdata = d; cnt_zero = z; gsync_req = g;
    endtask

    task automatic exp_out(input logic [7:0] v, input string tag);
        sb.push_back('{due: cyc + 1, is_rd: 1'b0, exp: {24'h0, v}, tag: tag});
    endtask

    task automatic step(input logic we, input logic addr, input logic [31:0] d,
                        input logic [3:0] z, input logic [3:0] g,
                        input logic [7:0] v, input string tag);
        drive(we, addr, d, z, g);
        exp_out(v, tag);
    endtask

    task automatic read(input logic addr, input logic [31:0] v, input string tag);
        drive(1'b0, addr, '0, '0, '0);
        sb.push_back('{due: cyc, is_rd: 1'b1, exp: v, tag: tag});
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] got;
            it = sb.pop_front();
            got = it.is_rd ? reg_rdata : {24'h0, out_en};
            checks++;
            if (it.due != cyc || got !== it.exp) begin
                failures++;
                $display("FAIL %s: got %h expected %h (due %0d, at %0d)",
                         it.tag, got, it.exp, it.due, cyc);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        step(0, 1, 0, 0, 0, 8'h00, "R1 out_en after reset");
        read(0, 32'h0, "R1 mode readback after reset");
        read(1, 32'h0, "R1 enable readback after reset");
        // R3 all outputs immediate
        step(1, 1, 32'h0000_00A5, 0, 0, 8'hA5, "R3 immediate write");
        read(1, 32'h0000_00A5, "R8 enable readback");
        // R2 mode 0xA1FA: out0,1=local out2,3=global out4=alias out5=now out6,7=local
        step(1, 0, 32'h5A5A_A1FA, 0, 0, 8'hA5, "R2 mode write leaves enables");
        read(0, 32'h0000_A1FA, "R2 mode readback, upper bits zero");
        // R4 bit4 (mode 1) and R3 bit5 (mode 0) immediate, rest pending
        step(1, 1, 32'h0000_005A, 0, 0, 8'h95, "R4 alias mode immediate, deferred bits hold");
        read(1, 32'h0000_0095, "R8 readback shows active not pending");
        // R10/R6 gen1 zero without request
        step(0, 1, 0, 4'b0010, 0, 8'h95, "R10 gen1 zero without request");
        // R5 gen0 zero applies bits 0,1
        step(0, 1, 0, 4'b0001, 0, 8'h96, "R5 local apply at gen0 zero");
        // R9 replace pending for gen3 and gen1
        step(1, 1, 32'h0000_00D2, 4'b1000, 0, 8'h96, "R5 zero on write edge does not apply");
        step(0, 1, 0, 4'b1000, 0, 8'hD6, "R9 newest pending applied at gen3 zero");
        // R6 global mode
        step(0, 1, 0, 4'b0010, 0, 8'hD6, "R6 zero without request holds");
        step(0, 1, 0, 4'b0010, 4'b0010, 8'hD6, "R6 zero on request edge holds");
        step(0, 1, 0, 4'b0010, 0, 8'hD2, "R6 zero after request applies");
        // R7 duplicate requests then consumption
        step(1, 1, 32'h0000_00D6, 0, 0, 8'hD2, "R7 pend gen1 bit2");
        step(0, 1, 0, 0, 4'b0010, 8'hD2, "R7 request one");
        step(0, 1, 0, 0, 4'b0010, 8'hD2, "R7 request two");
        step(0, 1, 0, 4'b0010, 0, 8'hD6, "R7 zero consumes request");
        step(1, 1, 32'h0000_00D2, 0, 0, 8'hD6, "R7 pend again");
        step(0, 1, 0, 4'b0010, 0, 8'hD6, "R7 zero after consumption holds");
        // R11 immediate write discards pending
        step(1, 0, 32'h0000_0000, 0, 0, 8'hD6, "R11 mode to immediate");
        step(1, 1, 32'h0000_00D6, 0, 0, 8'hD6, "R11 immediate write");
        step(1, 0, 32'h0000_A1FA, 0, 0, 8'hD6, "R11 mode back to deferred");
        step(0, 1, 0, 0, 4'b0010, 8'hD6, "R11 request");
        step(0, 1, 0, 4'b0010, 0, 8'hD6, "R11 discarded pending not applied");
        step(0, 1, 0, 4'b1111, 0, 8'hD6, "R10 all zeros no pending");
        drive(0, 1, 0, 0, 0);
        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d left expected 0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule